// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a synchronous DRAM interface (chip select, row strobe, column strobe, write enable, clock enable) together with the bank and address buses. On every rising clock it turns the pin pattern into one decoded command code. It also keeps an open or closed flag and the open row for each internal bank. Alongside the decoded command it reports the bank, the row or column field and the auto-precharge request. Four flags mark commands that break the bank or mode-load rules.

A run-time input picks where the pins are sampled. Either they pass straight to the decoder in the cycle they arrive, or they go through a register stage that holds them for one clock first. The data-mask input follows the same stage. It is presented at once as a write mask, and again two clocks later as a read output-disable. A controller model, a protocol monitor or a memory model can use the block to follow which rows are open and to catch illegal command sequences.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With cs_n high the command is INHIBIT (code 0), whatever the other pins are. With cs_n low, {ras_n,cas_n,we_n} decode as follows: 111 gives NOP (1), 011 gives ACTIVE (2), 101 gives READ (3), 100 gives WRITE (4), 110 gives BURST STOP (5), 010 gives PRECHARGE (6), 001 gives refresh, and 000 gives LOAD MODE (9). The code appears on cmd_o.
- R2: The refresh pattern decodes as AUTO REFRESH (7) when cke is high and as SELF REFRESH entry (8) when cke is low.
- R3: An ACTIVE with no violation opens bank ba and stores the 12-bit row addr for that bank. bank_open_o bit ba is set from the next cycle on. open_row_o always shows the stored row of the bank addressed by the current command.
- R4: On READ or WRITE, col_o is addr[9:0] and auto_pre_o is addr[10]. A legal READ or WRITE with addr[10] high closes its bank from the next cycle on. With addr[10] low the bank stays open.
- R5: A PRECHARGE with addr[10] low closes only bank ba. With addr[10] high it closes every bank and ba has no effect.
- R6: A READ or WRITE to a closed bank raises viol_closed_o in the same cycle and leaves bank_open_o unchanged.
- R7: An ACTIVE to a bank that is already open raises viol_open_o. Neither bank_open_o nor the stored row of that bank changes.
- R8: An ACTIVE, AUTO REFRESH or SELF REFRESH in the cycle right after a LOAD MODE raises viol_lmr_o, and a flagged ACTIVE does not open its bank. The same command two or more cycles after the LOAD MODE is not flagged.
- R9: An AUTO or SELF REFRESH issued while any bank is open raises viol_ref_o.
- R10: With reg_en low, the decoded outputs follow the pins in the same cycle. With reg_en high, they show the pins as sampled at the previous rising edge.
- R11: wr_mask_o equals the sampled dqm in the same cycle as the command. rd_hiz_o equals that dqm two clocks later.
- R12: After reset all banks are closed and rd_hiz_o is low. With reg_en high the register stage holds INHIBIT (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | High: one-clock input register stage; low: pass-through |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; selects auto or self refresh |
| dqm | input | 1 | Data mask |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row, column and precharge-select address |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Bank of the current command |
| row_o | output | 12 | Row field of the current command |
| col_o | output | 10 | Column field of the current command |
| auto_pre_o | output | 1 | Auto precharge requested by READ/WRITE |
| open_row_o | output | 12 | Stored row of the addressed bank |
| bank_open_o | output | 4 | Per-bank open flags |
| viol_closed_o | output | 1 | Access to a closed bank |
| viol_open_o | output | 1 | ACTIVE to an open bank |
| viol_lmr_o | output | 1 | ACTIVE or refresh too soon after LOAD MODE |
| viol_ref_o | output | 1 | Refresh with a bank open |
| wr_mask_o | output | 1 | Write data mask, zero delay |
| rd_hiz_o | output | 1 | Read output disable, two-clock delay |

## Verification
The bench sweeps every pin pattern with both cke levels, under both settings of the register stage. A decoder that mixed up the refresh and mode-load patterns, or that ignored cke, would print the wrong code. Directed sequences then target the state corners. One is a precharge-all aimed at a closed bank, which a design that honoured ba would get wrong by leaving the other banks open. Another is an ACTIVE to an open bank with a new row, which a tracker that wrote its row anyway would betray on open_row_o. A mode load followed at once by ACTIVE or self refresh checks the gap counter, and a tracker that opened the bank anyway would show up on bank_open_o. The mask test and the latency test look for an off-by-one in the two-clock read disable and in the one-clock input stage.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
   typedef enum logic [3:0] {
      CMD_INH  = 4'd0,
      CMD_NOP  = 4'd1,
      CMD_ACT  = 4'd2,
      CMD_RD   = 4'd3,
      CMD_WR   = 4'd4,
      CMD_BST  = 4'd5,
      CMD_PRE  = 4'd6,
      CMD_AREF = 4'd7,
      CMD_SREF = 4'd8,
      CMD_LMR  = 4'd9
   } cmd_e;
endpackage

// File: rtl/sdcmd_stage.sv
module sdcmd_stage #(
   parameter int          W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reg_en,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= RST_VAL;
      else        held_q <= d_i;
   end

   assign q_o = reg_en ? held_q : d_i;

   AST_STAGE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      reg_en |=> (!reg_en || q_o == $past(d_i)));   // R10
endmodule

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
   import sdcmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic cke,
   output cmd_e cmd_o
);
   always_comb begin
      if (cs_n) begin
         cmd_o = CMD_INH;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111: cmd_o = CMD_NOP;
            3'b011: cmd_o = CMD_ACT;
            3'b101: cmd_o = CMD_RD;
            3'b100: cmd_o = CMD_WR;
            3'b110: cmd_o = CMD_BST;
            3'b010: cmd_o = CMD_PRE;
            3'b001: cmd_o = cke ? CMD_AREF : CMD_SREF;
            3'b000: cmd_o = CMD_LMR;
         endcase
      end
   end
endmodule

// File: rtl/sdcmd_banks.sv
module sdcmd_banks
   import sdcmd_pkg::*;
#(
   parameter int BA_W    = 2,
   parameter int ROW_W   = 12,
   parameter int AP_BIT  = 10,
   parameter int LMR_GAP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_e             cmd_i,
   input  logic [BA_W-1:0]  ba_i,
   input  logic [ROW_W-1:0] addr_i,
   output logic [(1<<BA_W)-1:0] bank_open_o,
   output logic [ROW_W-1:0] open_row_o,
   output logic             viol_closed_o,
   output logic             viol_open_o,
   output logic             viol_lmr_o,
   output logic             viol_ref_o
);
   localparam int NBANK = 1 << BA_W;
   localparam int GAP_W = $clog2(LMR_GAP + 1);

   if (LMR_GAP < 1)      $error("LMR_GAP must be at least 1");
   if (AP_BIT >= ROW_W)  $error("AP_BIT must lie inside the address");

   logic [ROW_W-1:0] rows_q [NBANK];
   logic [GAP_W-1:0] gap_q;
   logic             is_ref, sel_open, any_viol;

   assign is_ref        = (cmd_i == CMD_AREF) || (cmd_i == CMD_SREF);
   assign sel_open      = bank_open_o[ba_i];
   assign viol_closed_o = ((cmd_i == CMD_RD) || (cmd_i == CMD_WR)) && !sel_open;
   assign viol_open_o   = (cmd_i == CMD_ACT) && sel_open;
   assign viol_lmr_o    = (gap_q != '0) && ((cmd_i == CMD_ACT) || is_ref);
   assign viol_ref_o    = is_ref && (|bank_open_o);
   assign any_viol      = viol_closed_o | viol_open_o | viol_lmr_o | viol_ref_o;
   assign open_row_o    = rows_q[ba_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_open_o <= '0;
         gap_q       <= '0;
         for (int i = 0; i < NBANK; i++) rows_q[i] <= '0;
      end else begin
         if (cmd_i == CMD_LMR)  gap_q <= GAP_W'(LMR_GAP - 1);
         else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
         if (!any_viol) begin
            case (cmd_i)
               CMD_ACT: begin
                  bank_open_o[ba_i] <= 1'b1;
                  rows_q[ba_i]      <= addr_i;
               end
               CMD_RD, CMD_WR: if (addr_i[AP_BIT]) bank_open_o[ba_i] <= 1'b0;
               CMD_PRE: begin
                  if (addr_i[AP_BIT]) bank_open_o       <= '0;
                  else                bank_open_o[ba_i] <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_ACT && !any_viol) |=> bank_open_o[$past(ba_i)]);   // R3
   AST_CLOSED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      viol_closed_o |=> $stable(bank_open_o));   // R6
   AST_OPEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      viol_open_o |=> $stable(bank_open_o));   // R7
   AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_PRE && addr_i[AP_BIT]) |=> (bank_open_o == '0));   // R5
   AST_VIOL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({viol_closed_o, viol_open_o}));   // R6

   if (LMR_GAP >= 2) begin : g_gap_chk
      AST_LMR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_i == CMD_LMR) |=> ((cmd_i != CMD_ACT && cmd_i != CMD_AREF &&
                                  cmd_i != CMD_SREF) || viol_lmr_o));   // R8
   end
endmodule

// File: rtl/sdcmd_dqm_pipe.sv
module sdcmd_dqm_pipe #(
   parameter int RD_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dqm_i,
   output logic wr_mask_o,
   output logic rd_hiz_o
);
   if (RD_LAT < 1) $error("RD_LAT must be at least 1");

   logic [RD_LAT-1:0] sh_q;
   logic [1:0]        warm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         warm_q <= '0;
      end else begin
         if (RD_LAT == 1) sh_q <= dqm_i;
         else             sh_q <= {sh_q[RD_LAT-2:0], dqm_i};
         if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
      end
   end

   assign wr_mask_o = dqm_i;
   assign rd_hiz_o  = sh_q[RD_LAT-1];

   if (RD_LAT == 2) begin : g_lat_chk
      AST_RD_HIZ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
         (warm_q == 2'd3) |-> (rd_hiz_o == $past(wr_mask_o, 2)));   // R11
   end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdcmd_pkg::*;
#(
   parameter int BA_W      = 2,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 10,
   parameter int AP_BIT    = 10,
   parameter int LMR_GAP   = 2,
   parameter int RD_LAT    = 2,
   parameter bit HAS_INREG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_en,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             cke,
   input  logic             dqm,
   input  logic [BA_W-1:0]  ba,
   input  logic [ROW_W-1:0] addr,
   output logic [3:0]       cmd_o,
   output logic [BA_W-1:0]  bank_o,
   output logic [ROW_W-1:0] row_o,
   output logic [COL_W-1:0] col_o,
   output logic             auto_pre_o,
   output logic [ROW_W-1:0] open_row_o,
   output logic [(1<<BA_W)-1:0] bank_open_o,
   output logic             viol_closed_o,
   output logic             viol_open_o,
   output logic             viol_lmr_o,
   output logic             viol_ref_o,
   output logic             wr_mask_o,
   output logic             rd_hiz_o
);
   localparam int SW = 6 + BA_W + ROW_W;
   localparam logic [SW-1:0] STAGE_RST = {1'b1, {(SW-1){1'b0}}};

   if (COL_W > AP_BIT) $error("column field must sit below the precharge bit");

   logic [SW-1:0]    pins, staged;
   logic             s_cs_n, s_ras_n, s_cas_n, s_we_n, s_cke, s_dqm;
   logic [BA_W-1:0]  s_ba;
   logic [ROW_W-1:0] s_addr;
   cmd_e             dec_cmd;

   assign pins = {cs_n, ras_n, cas_n, we_n, cke, dqm, ba, addr};

   if (HAS_INREG) begin : g_inreg
      sdcmd_stage #(.W(SW), .RST_VAL(STAGE_RST)) stage_i (
         .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .d_i(pins), .q_o(staged));
   end else begin : g_pass
      assign staged = pins;
   end

   assign {s_cs_n, s_ras_n, s_cas_n, s_we_n, s_cke, s_dqm, s_ba, s_addr} = staged;

   sdcmd_decode dec_i (
      .cs_n(s_cs_n), .ras_n(s_ras_n), .cas_n(s_cas_n), .we_n(s_we_n),
      .cke(s_cke), .cmd_o(dec_cmd));

   sdcmd_banks #(.BA_W(BA_W), .ROW_W(ROW_W), .AP_BIT(AP_BIT), .LMR_GAP(LMR_GAP)) banks_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(dec_cmd), .ba_i(s_ba), .addr_i(s_addr),
      .bank_open_o(bank_open_o), .open_row_o(open_row_o),
      .viol_closed_o(viol_closed_o), .viol_open_o(viol_open_o),
      .viol_lmr_o(viol_lmr_o), .viol_ref_o(viol_ref_o));

   sdcmd_dqm_pipe #(.RD_LAT(RD_LAT)) dqm_i (
      .clk(clk), .rst_n(rst_n), .dqm_i(s_dqm),
      .wr_mask_o(wr_mask_o), .rd_hiz_o(rd_hiz_o));

   assign cmd_o      = dec_cmd;
   assign bank_o     = s_ba;
   assign row_o      = s_addr;
   assign col_o      = s_addr[COL_W-1:0];
   assign auto_pre_o = ((dec_cmd == CMD_RD) || (dec_cmd == CMD_WR)) && s_addr[AP_BIT];
endmodule

// File: tb/sdram_cmd_tracker_tb_top.sv
module sdram_cmd_tracker_tb_top;
   localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                          P_WR = 4'b0100, P_PRE = 4'b0010, P_REF = 4'b0001,
                          P_LMR = 4'b0000;

   logic clk = 1'b0, rst_n = 1'b0, reg_en = 1'b0;
   logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, dqm = 1'b0;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic [3:0]  cmd_o;
   logic [1:0]  bank_o;
   logic [11:0] row_o, open_row_o;
   logic [9:0]  col_o;
   logic [3:0]  bank_open_o;
   logic auto_pre_o, viol_closed_o, viol_open_o, viol_lmr_o, viol_ref_o, wr_mask_o, rd_hiz_o;
   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sdram_cmd_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .cke(cke), .dqm(dqm), .ba(ba), .addr(addr),
      .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
      .auto_pre_o(auto_pre_o), .open_row_o(open_row_o), .bank_open_o(bank_open_o),
      .viol_closed_o(viol_closed_o), .viol_open_o(viol_open_o),
      .viol_lmr_o(viol_lmr_o), .viol_ref_o(viol_ref_o),
      .wr_mask_o(wr_mask_o), .rd_hiz_o(rd_hiz_o));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s mode=%0d actual=%0h expected=%0h", req, reg_en, act, exp);
      end
   endtask

   function automatic int exp_code(input logic [3:0] p, input logic k);
      if (p[3]) return 0;
      case (p[2:0])
         3'b111: return 1;
         3'b011: return 2;
         3'b101: return 3;
         3'b100: return 4;
         3'b110: return 5;
         3'b010: return 6;
         3'b001: return k ? 7 : 8;
         default: return 9;
      endcase
   endfunction

   // drive at a falling edge; return when the command is visible at the outputs
   task automatic present(input logic [3:0] p, input logic [1:0] b, input logic [11:0] a,
                          input logic k = 1'b1, input logic d = 1'b0);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = p;
      ba = b; addr = a; cke = k; dqm = d;
      if (reg_en) @(posedge clk);
      #5;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      {cs_n, ras_n, cas_n, we_n} = P_NOP; ba = 2'd0; addr = '0; cke = 1'b1; dqm = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #5;
      check("R12 banks closed", bank_open_o, 0);
      check("R12 rd_hiz low", rd_hiz_o, 0);
      if (reg_en) check("R12 stage inhibit", cmd_o, 0);
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int m = 0; m < 2; m++) begin
         reg_en = m[0];
         do_reset();
         // R1 R2: sweep every pin pattern at both clock-enable levels
         for (int v = 0; v < 32; v++) begin
            present(v[3:0], v[1:0], 12'(v * 37), v[4]);
            check(v[3:0] == P_REF ? "R2 refresh split" : "R1 decode",
                  cmd_o, exp_code(v[3:0], v[4]));
         end
         do_reset();
         // R3 open a bank
         present(P_ACT, 2'd1, 12'h5A5);
         check("R3 act code", cmd_o, 2);
         check("R3 row field", row_o, 12'h5A5);
         check("R3 bank field", bank_o, 1);
         check("R3 no viol", {viol_closed_o, viol_open_o, viol_lmr_o, viol_ref_o}, 0);
         present(P_NOP, 2'd1, 12'h000);
         check("R3 bank open", bank_open_o, 4'b0010);
         check("R3 stored row", open_row_o, 12'h5A5);
         // R4 read without auto precharge
         present(P_RD, 2'd1, 12'h123);
         check("R4 col field", col_o, 10'h123);
         check("R4 no auto pre", auto_pre_o, 0);
         check("R4 read legal", viol_closed_o, 0);
         // R6 read a closed bank
         present(P_RD, 2'd2, 12'h010);
         check("R6 closed flag", viol_closed_o, 1);
         present(P_NOP, 2'd2, 12'h000);
         check("R6 state kept", bank_open_o, 4'b0010);
         // R7 activate an open bank with a new row
         present(P_ACT, 2'd1, 12'h111);
         check("R7 open flag", viol_open_o, 1);
         present(P_NOP, 2'd1, 12'h000);
         check("R7 row kept", open_row_o, 12'h5A5);
         check("R7 state kept", bank_open_o, 4'b0010);
         // R9 refresh with a bank open
         present(P_REF, 2'd0, 12'h000, 1'b1);
         check("R9 refresh flag", viol_ref_o, 1);
         // R3 second bank, R5 single precharge
         present(P_ACT, 2'd3, 12'h007);
         present(P_NOP, 2'd3, 12'h000);
         check("R3 two open", bank_open_o, 4'b1010);
         present(P_PRE, 2'd1, 12'h000);
         present(P_NOP, 2'd3, 12'h000);
         check("R5 single close", bank_open_o, 4'b1000);
         // R4 write with auto precharge
         present(P_WR, 2'd3, 12'h405);
         check("R4 write code", cmd_o, 4);
         check("R4 auto pre", auto_pre_o, 1);
         check("R4 write col", col_o, 10'h005);
         present(P_NOP, 2'd3, 12'h000);
         check("R4 auto close", bank_open_o, 4'b0000);
         // R5 precharge all aimed at a closed bank
         present(P_ACT, 2'd0, 12'h001);
         present(P_ACT, 2'd2, 12'h002);
         present(P_NOP, 2'd0, 12'h000);
         check("R5 pre setup", bank_open_o, 4'b0101);
         present(P_PRE, 2'd1, 12'h400);
         present(P_NOP, 2'd0, 12'h000);
         check("R5 all closed", bank_open_o, 4'b0000);
         // R8 mode-load gap
         present(P_LMR, 2'd0, 12'h032);
         present(P_ACT, 2'd0, 12'h0AB);
         check("R8 act too soon", viol_lmr_o, 1);
         present(P_NOP, 2'd0, 12'h000);
         check("R8 act blocked", bank_open_o, 4'b0000);
         present(P_LMR, 2'd0, 12'h032);
         present(P_NOP, 2'd0, 12'h000);
         present(P_REF, 2'd0, 12'h000, 1'b1);
         check("R8 gap met", viol_lmr_o, 0);
         check("R9 refresh idle", viol_ref_o, 0);
         present(P_LMR, 2'd0, 12'h032);
         present(P_REF, 2'd0, 12'h000, 1'b0);
         check("R2 self refresh", cmd_o, 8);
         check("R8 self too soon", viol_lmr_o, 1);
         // R11 data mask
         present(P_NOP, 2'd0, 12'h000, 1'b1, 1'b0);
         present(P_NOP, 2'd0, 12'h000, 1'b1, 1'b0);
         present(P_NOP, 2'd0, 12'h000, 1'b1, 1'b1);
         check("R11 write mask now", wr_mask_o, 1);
         check("R11 hiz not yet", rd_hiz_o, 0);
         present(P_NOP, 2'd0, 12'h000, 1'b1, 1'b0);
         check("R11 write mask clear", wr_mask_o, 0);
         check("R11 hiz one clk", rd_hiz_o, 0);
         present(P_NOP, 2'd0, 12'h000, 1'b1, 1'b0);
         check("R11 hiz two clk", rd_hiz_o, 1);
         present(P_NOP, 2'd0, 12'h000, 1'b1, 1'b0);
         check("R11 hiz ends", rd_hiz_o, 0);
         // R10 stage latency
         present(P_NOP, 2'd0, 12'h000);
         @(negedge clk);
         {cs_n, ras_n, cas_n, we_n} = P_ACT; ba = 2'd2; addr = 12'h0CC;
         #5;
         check("R10 before edge", cmd_o, reg_en ? 1 : 2);
         @(posedge clk);
         #5;
         check("R10 after edge", cmd_o, reg_en ? 2 : 2);
         {cs_n, ras_n, cas_n, we_n} = P_NOP;
         @(posedge clk);
         #5;
         check("R10 bank opened", bank_open_o, 4'b0100);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule